// File: doc/BRIEF.md
# Video Raster Timing Generator with Front-Porch Prefetch

This block produces the raster timing for a video-mode display link. It drives horizontal sync, vertical sync, a data-enable window and a pixel output that is a fixed colour inside the visible area. Every dimension comes from plain configuration inputs: for each axis a visible size, a front porch, a sync width and a back porch, plus a polarity for each sync, a flag for the serial-panel interface type, a split flag and a worst-case fetch latency in lines.

Upstream pixel fetch logic needs warning before each frame. The block works out how many front-porch lines the fetch must start early and pulses a fetch-start strobe at the matching point of a frame-wide cycle counter. It also reports frame and line counts, raises a one-cycle interrupt at the start of each vertical sync, and takes in new configuration only between frames. A disable request is honoured only once a further frame has begun.

Top module: `vtg_top`

## Requirements
- R1: With the effective horizontal total H = visible + front porch + sync + back porch, and the vertical total V formed the same way, a line lasts H cycles and a frame lasts V*H cycles.
- R2: Each line and each frame begins with its sync pulse, then back porch, then visible region, then front porch. Data enable is high only when both axes are in their visible region. The frame holds visible width times visible height enabled cycles, and there are sync-width hsync cycles per line.
- R3: A polarity input of 1 makes that sync active-low. A polarity input of 0 makes it active-high. While stopped, each sync rests at its inactive level.
- R4: When the interface-type flag is 1, both syncs are active-high, whatever the polarity inputs say.
- R5: With worst-case lines W and S = vertical back porch + vertical sync width, the prefetch line count N is 0 when S >= W. Otherwise it is the whole vertical front porch when that porch is below W - S, and W - S lines otherwise. The prefetch enable output is 1 exactly when N is nonzero. N is shown on pf_lines_o.
- R6: A frame-wide counter is 1 on the first cycle of a frame and rises by one per cycle. When N is nonzero, fetch_start_o pulses for one cycle when that counter equals (V - N)*H + 1. This is the first cycle of line V - N, which is (V - N)*H cycles after the interrupt. When N is 0, no pulse occurs.
- R7: pixel_o shows the border colour 0 outside the visible window. Inside the window it shows the fixed active colour, or the underflow colour 0xFF while underflow_i is 1.
- R8: With the split flag set, the horizontal visible width, sync start (visible + front porch), sync end and total are each halved, rounding down. The porches and sync width then follow from these halved values.
- R9: The generator starts at the first clock edge at which en_i is 1 while stopped. Once running, it stops only at the end of a frame whose first cycle saw en_i at 0. A disable request made mid-frame therefore sees exactly one further interrupt. While stopped, no interrupt, enable or count changes occur.
- R10: The frame counter resets to 0 and increments on entry to each new frame, including the first after a start. line_cnt_o gives the current line, where line 0 is the first vertical sync line.
- R11: While running, a configuration change takes effect only from the first cycle of the next frame.
- R12: vsync_irq_o is a one-cycle pulse on the first cycle of each frame (the start of vertical sync). It stays 0 while slave_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run request |
| split_i | input | 1 | Halve horizontal geometry for a two-generator panel |
| dsi_i | input | 1 | Interface-type flag; 1 forces active-high syncs |
| slave_i | input | 1 | Suppresses the vsync interrupt |
| hpol_i | input | 1 | Hsync polarity, 1 = active-low |
| vpol_i | input | 1 | Vsync polarity, 1 = active-low |
| h_act_i | input | HW | Visible width |
| h_fp_i | input | HW | Horizontal front porch |
| h_sw_i | input | HW | Hsync width |
| h_bp_i | input | HW | Horizontal back porch |
| v_act_i | input | VW | Visible height |
| v_fp_i | input | VW | Vertical front porch |
| v_sw_i | input | VW | Vsync width |
| v_bp_i | input | VW | Vertical back porch |
| wc_lines_i | input | VW | Worst-case fetch latency in lines |
| underflow_i | input | 1 | Pixel source underflow indication |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pixel_o | output | PIXW | Pixel colour |
| fetch_start_o | output | 1 | Prefetch start strobe |
| pf_en_o | output | 1 | Prefetch enabled |
| pf_lines_o | output | VW | Prefetch line count N |
| vsync_irq_o | output | 1 | Per-frame interrupt pulse |
| running_o | output | 1 | Generator running |
| frame_cnt_o | output | FRW | Frame counter |
| line_cnt_o | output | VW+2 | Current line |

## Verification
The prefetch rule is tried with a table of vertical geometries. One case has sync plus back porch at or above the worst case, so there is no pulse. Other cases have a front porch below the need (the whole porch is used), above it, and equal to it. A case with a need of one line is also included. Together these separate the three branches and the off-by-one boundaries. Each case also measures frame length, pulse offset and pulse line, which tells a wrong total or a wrong counter origin apart from a wrong N. Directed frames then vary polarity, the interface-type flag, split mode, underflow, slave role, mid-frame configuration changes and mid-frame disable. Each of these changes only one visible behaviour.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

   // Prefetch line count from worst-case lines, start-of-frame lines and front porch
   function automatic logic [31:0] pf_line_count(input logic [31:0] wc,
                                                 input logic [31:0] sof,
                                                 input logic [31:0] fp);
      logic [31:0] need;
      if (sof >= wc) return 32'd0;
      need = wc - sof;
      if (fp < need) return fp;
      return need;
   endfunction

   // Pin level of a sync given its active state and polarity choice
   function automatic logic sync_level(input logic active,
                                       input logic low_pol,
                                       input logic force_high);
      return active ^ (low_pol & ~force_high);
   endfunction

endpackage

// File: rtl/vtg_axis_geom.sv
module vtg_axis_geom #(
   parameter int FW       = 12,
   parameter bit SPLIT_EN = 1'b0,
   localparam int TW      = FW + 2
) (
   input  logic [FW-1:0] sw_i,
   input  logic [FW-1:0] bp_i,
   input  logic [FW-1:0] act_i,
   input  logic [FW-1:0] fp_i,
   input  logic          halve_i,
   output logic [TW-1:0] sync_end_o,
   output logic [TW-1:0] act_start_o,
   output logic [TW-1:0] act_end_o,
   output logic [TW-1:0] total_o
);

   // Boundaries measured from the start of the visible region
   logic [TW-1:0] vis_end, sync_beg, sync_fin, tot;
   logic [TW-1:0] vis_end_e, sync_beg_e, sync_fin_e, tot_e;

   assign vis_end  = TW'(act_i);
   assign sync_beg = vis_end + TW'(fp_i);
   assign sync_fin = sync_beg + TW'(sw_i);
   assign tot      = sync_fin + TW'(bp_i);

   generate
      if (SPLIT_EN) begin : g_split
         assign vis_end_e  = halve_i ? (vis_end  >> 1) : vis_end;
         assign sync_beg_e = halve_i ? (sync_beg >> 1) : sync_beg;
         assign sync_fin_e = halve_i ? (sync_fin >> 1) : sync_fin;
         assign tot_e      = halve_i ? (tot      >> 1) : tot;
      end else begin : g_full
         logic unused_halve;
         assign unused_halve = halve_i;
         assign vis_end_e  = vis_end;
         assign sync_beg_e = sync_beg;
         assign sync_fin_e = sync_fin;
         assign tot_e      = tot;
      end
   endgenerate

   // Re-origin at sync start: sync, back porch, visible, front porch
   assign sync_end_o  = sync_fin_e - sync_beg_e;
   assign act_start_o = tot_e - sync_beg_e;
   assign act_end_o   = tot_e - sync_beg_e + vis_end_e;
   assign total_o     = tot_e;

endmodule

// File: rtl/vtg_raster.sv
module vtg_raster #(
   parameter int HTW = 14,
   parameter int VTW = 14,
   parameter int FRW = 16,
   localparam int FCW = HTW + VTW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en_i,
   input  logic [HTW-1:0] h_total_i,
   input  logic [HTW-1:0] h_sync_end_i,
   input  logic [HTW-1:0] h_act_start_i,
   input  logic [HTW-1:0] h_act_end_i,
   input  logic [VTW-1:0] v_total_i,
   input  logic [VTW-1:0] v_sync_end_i,
   input  logic [VTW-1:0] v_act_start_i,
   input  logic [VTW-1:0] v_act_end_i,
   output logic           running_o,
   output logic           load_o,
   output logic           frame_start_o,
   output logic [HTW-1:0] hcnt_o,
   output logic [VTW-1:0] vcnt_o,
   output logic [FCW-1:0] fcnt_o,
   output logic [FRW-1:0] frame_cnt_o,
   output logic           hs_act_o,
   output logic           vs_act_o,
   output logic           de_o
);

   logic           running_q, stop_arm_q;
   logic [HTW-1:0] hcnt_q;
   logic [VTW-1:0] vcnt_q;
   logic [FCW-1:0] fcnt_q;
   logic [FRW-1:0] frame_cnt_q;
   logic           h_last, v_last, frame_last, frame_start;

   assign h_last      = hcnt_q == (h_total_i - HTW'(1));
   assign v_last      = vcnt_q == (v_total_i - VTW'(1));
   assign frame_last  = running_q & h_last & v_last;
   assign frame_start = running_q & (hcnt_q == '0) & (vcnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q   <= 1'b0;
         stop_arm_q  <= 1'b0;
         hcnt_q      <= '0;
         vcnt_q      <= '0;
         fcnt_q      <= '0;
         frame_cnt_q <= '0;
      end else if (!running_q) begin
         if (en_i) begin
            running_q   <= 1'b1;
            stop_arm_q  <= 1'b0;
            hcnt_q      <= '0;
            vcnt_q      <= '0;
            fcnt_q      <= FCW'(1);
            frame_cnt_q <= frame_cnt_q + FRW'(1);
         end
      end else begin
         if (frame_start && !en_i) stop_arm_q <= 1'b1;
         if (frame_last) begin
            hcnt_q <= '0;
            vcnt_q <= '0;
            fcnt_q <= FCW'(1);
            if (stop_arm_q) begin
               running_q  <= 1'b0;
               stop_arm_q <= 1'b0;
            end else begin
               frame_cnt_q <= frame_cnt_q + FRW'(1);
            end
         end else begin
            fcnt_q <= fcnt_q + FCW'(1);
            if (h_last) begin
               hcnt_q <= '0;
               vcnt_q <= vcnt_q + VTW'(1);
            end else begin
               hcnt_q <= hcnt_q + HTW'(1);
            end
         end
      end
   end

   assign running_o     = running_q;
   assign load_o        = !running_q | frame_last;
   assign frame_start_o = frame_start;
   assign hcnt_o        = hcnt_q;
   assign vcnt_o        = vcnt_q;
   assign fcnt_o        = fcnt_q;
   assign frame_cnt_o   = frame_cnt_q;
   assign hs_act_o      = running_q & (hcnt_q < h_sync_end_i);
   assign vs_act_o      = running_q & (vcnt_q < v_sync_end_i);
   assign de_o          = running_q &
                          (hcnt_q >= h_act_start_i) & (hcnt_q < h_act_end_i) &
                          (vcnt_q >= v_act_start_i) & (vcnt_q < v_act_end_i);

   // R9: the generator only stops on the last cycle of a frame
   a_r9_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running_q) |-> $past(frame_last));

   // R10: line and pixel positions stay inside the frame
   a_r10_pos_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      running_q |-> (vcnt_q < v_total_i) && (hcnt_q < h_total_i));

   // R6: the frame-wide counter restarts at 1 on each frame's first cycle
   a_r6_fcnt_origin: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> fcnt_q == FCW'(1));

endmodule

// File: rtl/vtg_prefetch.sv
module vtg_prefetch #(
   parameter int VW  = 12,
   parameter int HTW = 14,
   parameter int VTW = 14,
   localparam int FCW = HTW + VTW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           running_i,
   input  logic [VW-1:0]  v_sw_i,
   input  logic [VW-1:0]  v_bp_i,
   input  logic [VW-1:0]  v_fp_i,
   input  logic [VW-1:0]  wc_lines_i,
   input  logic [HTW-1:0] h_total_i,
   input  logic [VTW-1:0] v_total_i,
   input  logic [FCW-1:0] fcnt_i,
   output logic           pf_en_o,
   output logic [VW-1:0]  pf_lines_o,
   output logic           fetch_o
);
   import vtg_pkg::*;

   logic [31:0]    sof_lines, n_full;
   logic [VW-1:0]  n_lines;
   logic [VTW-1:0] fetch_line;
   logic [FCW-1:0] fetch_pos;

   assign sof_lines  = 32'(v_bp_i) + 32'(v_sw_i);
   assign n_full     = pf_line_count(32'(wc_lines_i), sof_lines, 32'(v_fp_i));
   assign n_lines    = n_full[VW-1:0];
   assign fetch_line = v_total_i - VTW'(n_lines);
   assign fetch_pos  = FCW'(fetch_line) * FCW'(h_total_i) + FCW'(1);

   assign pf_en_o    = n_lines != '0;
   assign pf_lines_o = n_lines;
   assign fetch_o    = running_i & pf_en_o & (fcnt_i == fetch_pos);

   // R5: prefetch never reaches beyond the front porch
   a_r5_within_porch: assert property (@(posedge clk) disable iff (!rst_n)
      pf_lines_o <= v_fp_i);

endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
   parameter int            HW            = 12,
   parameter int            VW            = 12,
   parameter int            FRW           = 16,
   parameter int            PIXW          = 24,
   parameter logic [PIXW-1:0] ACTIVE_CLR    = 'h808080,
   parameter logic [PIXW-1:0] BORDER_CLR    = 'h0,
   parameter logic [PIXW-1:0] UNDERFLOW_CLR = 'hFF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_i,
   input  logic            split_i,
   input  logic            dsi_i,
   input  logic            slave_i,
   input  logic            hpol_i,
   input  logic            vpol_i,
   input  logic [HW-1:0]   h_act_i,
   input  logic [HW-1:0]   h_fp_i,
   input  logic [HW-1:0]   h_sw_i,
   input  logic [HW-1:0]   h_bp_i,
   input  logic [VW-1:0]   v_act_i,
   input  logic [VW-1:0]   v_fp_i,
   input  logic [VW-1:0]   v_sw_i,
   input  logic [VW-1:0]   v_bp_i,
   input  logic [VW-1:0]   wc_lines_i,
   input  logic            underflow_i,
   output logic            hsync_o,
   output logic            vsync_o,
   output logic            de_o,
   output logic [PIXW-1:0] pixel_o,
   output logic            fetch_start_o,
   output logic            pf_en_o,
   output logic [VW-1:0]   pf_lines_o,
   output logic            vsync_irq_o,
   output logic            running_o,
   output logic [FRW-1:0]  frame_cnt_o,
   output logic [VW+1:0]   line_cnt_o
);
   import vtg_pkg::*;

   localparam int HTW = HW + 2;
   localparam int VTW = VW + 2;
   localparam int FCW = HTW + VTW;

   generate
      if (HW < 2 || VW < 2) begin : g_bad_narrow
         $error("vtg_top: HW and VW must be at least 2");
      end
      if (VW > 29 || HW > 29) begin : g_bad_wide
         $error("vtg_top: HW and VW must not exceed 29");
      end
      if (FRW < 1 || PIXW < 1) begin : g_bad_misc
         $error("vtg_top: FRW and PIXW must be positive");
      end
   endgenerate

   // Working configuration, copied from the inputs only at frame boundaries
   logic [HW-1:0] hact_q, hfp_q, hsw_q, hbp_q;
   logic [VW-1:0] vact_q, vfp_q, vsw_q, vbp_q, wc_q;
   logic          split_q, dsi_q, hpol_q, vpol_q;
   logic          load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hact_q  <= '0; hfp_q <= '0; hsw_q <= '0; hbp_q <= '0;
         vact_q  <= '0; vfp_q <= '0; vsw_q <= '0; vbp_q <= '0;
         wc_q    <= '0;
         split_q <= 1'b0; dsi_q <= 1'b0; hpol_q <= 1'b0; vpol_q <= 1'b0;
      end else if (load) begin
         hact_q  <= h_act_i; hfp_q <= h_fp_i; hsw_q <= h_sw_i; hbp_q <= h_bp_i;
         vact_q  <= v_act_i; vfp_q <= v_fp_i; vsw_q <= v_sw_i; vbp_q <= v_bp_i;
         wc_q    <= wc_lines_i;
         split_q <= split_i; dsi_q <= dsi_i; hpol_q <= hpol_i; vpol_q <= vpol_i;
      end
   end

   logic [HTW-1:0] h_sync_end, h_act_start, h_act_end, h_total;
   logic [VTW-1:0] v_sync_end, v_act_start, v_act_end, v_total;

   vtg_axis_geom #(.FW(HW), .SPLIT_EN(1'b1)) u_hgeom (
      .sw_i(hsw_q), .bp_i(hbp_q), .act_i(hact_q), .fp_i(hfp_q),
      .halve_i(split_q),
      .sync_end_o(h_sync_end), .act_start_o(h_act_start),
      .act_end_o(h_act_end), .total_o(h_total));

   vtg_axis_geom #(.FW(VW), .SPLIT_EN(1'b0)) u_vgeom (
      .sw_i(vsw_q), .bp_i(vbp_q), .act_i(vact_q), .fp_i(vfp_q),
      .halve_i(1'b0),
      .sync_end_o(v_sync_end), .act_start_o(v_act_start),
      .act_end_o(v_act_end), .total_o(v_total));

   logic           running, frame_start, hs_act, vs_act, de;
   logic [HTW-1:0] hcnt;
   logic [VTW-1:0] vcnt;
   logic [FCW-1:0] fcnt;

   vtg_raster #(.HTW(HTW), .VTW(VTW), .FRW(FRW)) u_raster (
      .clk(clk), .rst_n(rst_n), .en_i(en_i),
      .h_total_i(h_total), .h_sync_end_i(h_sync_end),
      .h_act_start_i(h_act_start), .h_act_end_i(h_act_end),
      .v_total_i(v_total), .v_sync_end_i(v_sync_end),
      .v_act_start_i(v_act_start), .v_act_end_i(v_act_end),
      .running_o(running), .load_o(load), .frame_start_o(frame_start),
      .hcnt_o(hcnt), .vcnt_o(vcnt), .fcnt_o(fcnt),
      .frame_cnt_o(frame_cnt_o),
      .hs_act_o(hs_act), .vs_act_o(vs_act), .de_o(de));

   vtg_prefetch #(.VW(VW), .HTW(HTW), .VTW(VTW)) u_prefetch (
      .clk(clk), .rst_n(rst_n), .running_i(running),
      .v_sw_i(vsw_q), .v_bp_i(vbp_q), .v_fp_i(vfp_q), .wc_lines_i(wc_q),
      .h_total_i(h_total), .v_total_i(v_total), .fcnt_i(fcnt),
      .pf_en_o(pf_en_o), .pf_lines_o(pf_lines_o), .fetch_o(fetch_start_o));

   assign hsync_o     = sync_level(hs_act, hpol_q, dsi_q);
   assign vsync_o     = sync_level(vs_act, vpol_q, dsi_q);
   assign de_o        = de;
   assign vsync_irq_o = frame_start & ~slave_i;
   assign running_o   = running;
   assign line_cnt_o  = vcnt;

   always_comb begin
      if (!de)              pixel_o = BORDER_CLR;
      else if (underflow_i) pixel_o = UNDERFLOW_CLR;
      else                  pixel_o = ACTIVE_CLR;
   end

   // R12: the interrupt never lasts more than one cycle
   a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      vsync_irq_o |=> !vsync_irq_o);

   // R6: the fetch strobe lands on a line start inside the vertical front porch
   a_r6_fetch_in_porch: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_start_o |-> (hcnt == '0) && (vcnt >= v_act_end));

   // R11: geometry in use holds steady within a running frame
   a_r11_cfg_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !frame_start) |-> ($stable(h_total) && $stable(v_total)));

   // R2: visible region never overlaps either sync pulse
   a_r2_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (!hs_act && !vs_act));

endmodule

// File: tb/sim_vtg_top.sv
module sim_vtg_top;

   localparam logic [23:0] ACT_C = 24'h3C5A7E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i = 1'b0, split_i = 1'b0, dsi_i = 1'b0, slave_i = 1'b0;
   logic        hpol_i = 1'b0, vpol_i = 1'b0, underflow_i = 1'b0;
   logic [11:0] h_act_i = 12'd8, h_fp_i = 12'd3, h_sw_i = 12'd2, h_bp_i = 12'd3;
   logic [11:0] v_act_i = 12'd4, v_fp_i = 12'd3, v_sw_i = 12'd1, v_bp_i = 12'd2;
   logic [11:0] wc_lines_i = 12'd5;
   logic        hsync_o, vsync_o, de_o, fetch_start_o, pf_en_o, vsync_irq_o, running_o;
   logic [23:0] pixel_o;
   logic [11:0] pf_lines_o;
   logic [15:0] frame_cnt_o;
   logic [13:0] line_cnt_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   vtg_top #(.ACTIVE_CLR(ACT_C)) u0 (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .split_i(split_i), .dsi_i(dsi_i),
      .slave_i(slave_i), .hpol_i(hpol_i), .vpol_i(vpol_i),
      .h_act_i(h_act_i), .h_fp_i(h_fp_i), .h_sw_i(h_sw_i), .h_bp_i(h_bp_i),
      .v_act_i(v_act_i), .v_fp_i(v_fp_i), .v_sw_i(v_sw_i), .v_bp_i(v_bp_i),
      .wc_lines_i(wc_lines_i), .underflow_i(underflow_i),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pixel_o(pixel_o),
      .fetch_start_o(fetch_start_o), .pf_en_o(pf_en_o), .pf_lines_o(pf_lines_o),
      .vsync_irq_o(vsync_irq_o), .running_o(running_o),
      .frame_cnt_o(frame_cnt_o), .line_cnt_o(line_cnt_o));

   always #4 clk = ~clk;

   // Columns: vsync width, vertical back porch, vertical front porch, worst case, expected N
   localparam int VEC [0:5][0:4] = '{
      '{1, 2, 3, 5, 2},
      '{2, 3, 4, 5, 0},
      '{1, 1, 3, 8, 3},
      '{1, 1, 6, 5, 3},
      '{2, 2, 5, 5, 1},
      '{1, 1, 3, 5, 3}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      finish_run();
   end

   // Starts on an interrupt cycle; returns on the next interrupt cycle
   task automatic measure(input bit uf, output int len, output int fk, output int fline,
                          output int de_n, output int hs_n, output bit pix_ok);
      logic [23:0] expc;
      len = -1; fk = -1; fline = -1; de_n = 0; hs_n = 0; pix_ok = 1'b1;
      for (int k = 0; k < 6000; k++) begin
         if (k > 0) begin
            @(negedge clk);
            if (vsync_irq_o) begin
               len = k;
               break;
            end
         end
         if (de_o) de_n++;
         if (hsync_o) hs_n++;
         if (fetch_start_o && fk < 0) begin
            fk = k;
            fline = int'(line_cnt_o);
         end
         expc = de_o ? (uf ? 24'hFF : ACT_C) : 24'h0;
         if (pixel_o != expc) pix_ok = 1'b0;
      end
   endtask

   initial begin
      int len, fk, fline, de_n, hs_n, vt, fexp, f0, k, irqs;
      bit pix_ok;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      chk("R9 running after reset", int'(running_o), 0);
      chk("R10 frame count after reset", int'(frame_cnt_o), 0);
      chk("R12 irq after reset", int'(vsync_irq_o), 0);
      chk("R2 de after reset", int'(de_o), 0);
      chk("R3 idle hsync level", int'(hsync_o), 0);

      // R9: idle with en_i low changes nothing
      repeat (20) @(negedge clk);
      chk("R9 idle stays stopped", int'(running_o), 0);
      chk("R9 idle frame count", int'(frame_cnt_o), 0);

      en_i = 1'b1;
      @(negedge clk);
      chk("R9 start next edge", int'(running_o), 1);
      chk("R12 irq at first frame", int'(vsync_irq_o), 1);
      chk("R10 first frame count", int'(frame_cnt_o), 1);
      chk("R10 line at frame start", int'(line_cnt_o), 0);
      chk("R2 vsync first", int'(vsync_o), 1);
      chk("R2 hsync first", int'(hsync_o), 1);

      measure(1'b0, len, fk, fline, de_n, hs_n, pix_ok);
      chk("R1 frame length", len, 160);
      chk("R2 enabled cycles", de_n, 32);
      chk("R2 hsync cycles", hs_n, 20);
      chk("R6 fetch offset", fk, 128);
      chk("R6 fetch line", fline, 8);
      chk("R5 lines default", int'(pf_lines_o), 2);
      chk("R7 pixel colours", int'(pix_ok), 1);
      chk("R10 frame count increments", int'(frame_cnt_o), 2);

      // Vector table: prefetch rule across vertical geometries
      vt = 10;
      for (int i = 0; i < 6; i++) begin
         v_sw_i = 12'(VEC[i][0]); v_bp_i = 12'(VEC[i][1]);
         v_fp_i = 12'(VEC[i][2]); wc_lines_i = 12'(VEC[i][3]);
         measure(1'b0, len, fk, fline, de_n, hs_n, pix_ok);
         chk("R11 old config holds for current frame", len, vt * 16);
         vt = VEC[i][0] + VEC[i][1] + 4 + VEC[i][2];
         fexp = (VEC[i][4] != 0) ? (vt - VEC[i][4]) * 16 : -1;
         chk("R5 prefetch lines", int'(pf_lines_o), VEC[i][4]);
         chk("R5 prefetch enable", int'(pf_en_o), (VEC[i][4] != 0) ? 1 : 0);
         measure(1'b0, len, fk, fline, de_n, hs_n, pix_ok);
         chk("R1 vector frame length", len, vt * 16);
         chk("R6 vector fetch offset", fk, fexp);
         if (fexp >= 0) chk("R6 vector fetch line", fline, vt - VEC[i][4]);
      end

      // Back to the default geometry
      v_sw_i = 12'd1; v_bp_i = 12'd2; v_fp_i = 12'd3; wc_lines_i = 12'd5;
      measure(1'b0, len, fk, fline, de_n, hs_n, pix_ok);

      // R7: underflow colour in the window
      underflow_i = 1'b1;
      measure(1'b1, len, fk, fline, de_n, hs_n, pix_ok);
      chk("R7 underflow colour", int'(pix_ok), 1);
      underflow_i = 1'b0;

      // R3: active-low syncs
      hpol_i = 1'b1; vpol_i = 1'b1;
      measure(1'b0, len, fk, fline, de_n, hs_n, pix_ok);
      chk("R3 hsync low in sync", int'(hsync_o), 0);
      chk("R3 vsync low in sync", int'(vsync_o), 0);
      repeat (3) @(negedge clk);
      chk("R3 hsync high after sync", int'(hsync_o), 1);
      while (!vsync_irq_o) @(negedge clk);

      // R4: interface-type flag forces active-high
      dsi_i = 1'b1;
      measure(1'b0, len, fk, fline, de_n, hs_n, pix_ok);
      chk("R4 hsync forced high", int'(hsync_o), 1);
      chk("R4 vsync forced high", int'(vsync_o), 1);
      dsi_i = 1'b0; hpol_i = 1'b0; vpol_i = 1'b0;
      measure(1'b0, len, fk, fline, de_n, hs_n, pix_ok);

      // R8: split mode halves horizontal geometry (8,11,13,16 -> 4,5,6,8)
      split_i = 1'b1;
      measure(1'b0, len, fk, fline, de_n, hs_n, pix_ok);
      measure(1'b0, len, fk, fline, de_n, hs_n, pix_ok);
      chk("R8 split frame length", len, 80);
      chk("R8 split enabled cycles", de_n, 16);
      chk("R8 split hsync cycles", hs_n, 10);
      chk("R8 split fetch offset", fk, 64);
      split_i = 1'b0;
      measure(1'b0, len, fk, fline, de_n, hs_n, pix_ok);

      // R12: slave role suppresses the interrupt but frames continue
      slave_i = 1'b1;
      f0 = int'(frame_cnt_o);
      irqs = 0;
      for (int j = 0; j < 400; j++) begin
         @(negedge clk);
         if (vsync_irq_o) irqs++;
      end
      chk("R12 slave no irq", irqs, 0);
      chk("R10 slave frames counted", int'(frame_cnt_o), f0 + 2);
      slave_i = 1'b0;
      while (!vsync_irq_o) @(negedge clk);

      // R9: mid-frame disable yields one more interrupt, stop at frame end
      irqs = 0;
      k = 0;
      for (int j = 1; j < 2000; j++) begin
         @(negedge clk);
         if (j == 20) en_i = 1'b0;
         if (vsync_irq_o) irqs++;
         if (!running_o) begin
            k = j;
            break;
         end
      end
      chk("R9 one irq after disable", irqs, 1);
      chk("R9 stop at frame end", k, 320);
      f0 = int'(frame_cnt_o);
      irqs = 0;
      de_n = 0;
      for (int j = 0; j < 200; j++) begin
         @(negedge clk);
         if (vsync_irq_o) irqs++;
         if (de_o) de_n++;
      end
      chk("R9 stopped no irq", irqs, 0);
      chk("R9 stopped no de", de_n, 0);
      chk("R9 stopped frame count", int'(frame_cnt_o), f0);

      en_i = 1'b1;
      @(negedge clk);
      chk("R10 restart increments", int'(frame_cnt_o), f0 + 1);
      chk("R12 restart irq", int'(vsync_irq_o), 1);

      finish_run();
   end

endmodule